// File: doc/BRIEF.md
# One-Wire Master Register Interface

This block is the host-facing side of a one-wire bus master. A byte-wide register space of six locations lets software program a clock divisor and a control byte, issue bus reset pulses, and send or receive bytes. The block hands each job to a separate bit-level engine. That engine does the slot timing, shifts each byte least-significant bit first, and reports completion together with the sampled byte or the presence answer.

The block keeps six status flags and raises an interrupt line. A byte read on the bus is done by writing 0xFF to the data register and then collecting the byte the engine sampled. Reading the status register acknowledges the interrupt. Reading the data register drains the receive path. A software reset, issued through the command register, abandons any job in flight.

A small controller sequences the jobs with three named states:
- `ST_IDLE`: no job is running.
- `ST_RESET`: a bus reset job is running.
- `ST_BYTE`: a byte job is running.

Its transitions are:
- `ST_IDLE`→`ST_RESET` when a reset is requested. This request has priority over a pending byte.
- `ST_IDLE`→`ST_BYTE` when the transmit buffer holds a byte.
- `ST_RESET`→`ST_IDLE` and `ST_BYTE`→`ST_IDLE` on engine completion or on software reset.

Top module: `owm_regif`

## Requirements
- R1: After reset, status reads 0x0C (transmit buffer empty at bit 2, transmit shifter empty at bit 3, every other flag clear). The interrupt enable, clock divisor, control and data registers read 0. The interrupt output sits at its inactive level, which is high, because active-low is the reset polarity.
- R2: Register offsets are: 0 command, 1 data, 2 status, 3 interrupt enable, 4 clock divisor, 5 control. The enable, divisor and control registers read back what was written. The divisor drives `clk_div` and the control byte drives `ctrl`.
- R3: Writing offset 1 fills the transmit buffer and clears the buffer-empty flag (bit 2). When the controller is idle, the next cycle pulses `eng_start` with `eng_reset_job`=0 and `eng_tx_byte` equal to the byte. On that cycle bit 2 sets and the shifter-empty flag (bit 3) clears. Engine completion sets bit 3 and places `eng_rx_byte` in the receive buffer.
- R4: A completed byte sets receive-buffer-full (bit 4) when the buffer is empty. Otherwise it is held in the receive shifter and sets receive-shifter-full (bit 5). Reading offset 1 returns the buffer and then either clears bit 4 or moves the held byte in, clearing bit 5. Bytes are read back in arrival order.
- R5: Writing command bit 0 while idle starts a reset job in the same cycle, with `eng_start`=1 and `eng_reset_job`=1. Completion sets presence-cycle-done (status bit 0) and copies `eng_no_slave` into the presence result (status bit 1), where 1 means no slave answered. The request is ignored while a job runs.
- R6: Reading offset 2 clears status bit 0 and the pending interrupt. Status bits 1 to 5 keep their values.
- R7: Enable bits 0, 2, 3, 4 and 5 arm status bits 0, 2, 3, 4 and 5. A 0→1 change of an armed flag latches a pending interrupt. A flag that is already set when it becomes armed raises nothing. Enable bit 1 selects the output polarity: 1 makes the output high while an interrupt is pending, 0 makes it low.
- R8: Writing command bit 5 aborts a running job with a one-cycle `eng_abort` pulse, returns to idle, and forces status to 0x0C. It also drops the pending interrupt, and a later engine completion for the abandoned job has no effect.
- R9: `bus_force_low` follows command bit 2 only while enable bit 6 is set. Command bit 3 reads `bus_level`. Command bits 1 and 7 drive `search_mode` and `overdrive`. Command bit 0 reads 1 while a reset job runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| intr | output | 1 | Interrupt line, programmable polarity |
| eng_start | output | 1 | One-cycle job start to the bit engine |
| eng_reset_job | output | 1 | With `eng_start`: 1 = reset job, 0 = byte job |
| eng_tx_byte | output | 8 | Byte for a byte job |
| eng_abort | output | 1 | Abandon the running job |
| eng_done | input | 1 | One-cycle job completion from the engine |
| eng_no_slave | input | 1 | With `eng_done` of a reset job: no presence answer |
| eng_rx_byte | input | 8 | With `eng_done` of a byte job: sampled byte |
| bus_level | input | 1 | Present bus level |
| bus_force_low | output | 1 | Drive the bus low directly |
| search_mode | output | 1 | Search accelerator select |
| overdrive | output | 1 | Overdrive speed select |
| clk_div | output | 8 | Clock divisor setting |
| ctrl | output | 8 | Control register contents |

## Verification
The byte path is driven from a table of transmit and receive pairs. The pairs include all-ones (the read idiom), all-zeros, alternating patterns and single-bit bytes, so a bit swap, a dropped bit, or a stale buffer in either direction shows up in the engine's captured byte or in the data register.

Back-to-back bytes without a data read show whether the receive shifter preserves ordering. Reset jobs with and without a presence answer tell the presence-done flag apart from the presence result. Toggling the enable register against already-set flags separates edge-latched interrupts from level ones. A software reset landed mid-byte shows whether the job is truly abandoned, rather than completing late.

// File: rtl/owm_pkg.sv
package owm_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;
    localparam int FLAG_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd5;

    // status flag positions
    localparam int F_PD   = 0;
    localparam int F_PRES = 1;
    localparam int F_TBE  = 2;
    localparam int F_TSE  = 3;
    localparam int F_RBF  = 4;
    localparam int F_RSF  = 5;

    localparam logic [FLAG_W-1:0] FLAGS_IDLE = 6'b001100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESET = 2'd1,
        ST_BYTE  = 2'd2
    } job_state_t;
endpackage

// File: rtl/owm_job_fsm.sv
module owm_job_fsm
    import owm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic reset_req,
    input  logic tx_full,
    input  logic eng_done,
    output logic eng_start,
    output logic eng_reset_job,
    output logic eng_abort,
    output logic load_tx,
    output logic reset_done,
    output logic byte_done,
    output logic busy,
    output logic busy_reset
);
    job_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (soft_rst)       state_d = ST_IDLE;
                else if (reset_req) state_d = ST_RESET;
                else if (tx_full)   state_d = ST_BYTE;
            end
            ST_RESET: if (soft_rst || eng_done) state_d = ST_IDLE;
            ST_BYTE:  if (soft_rst || eng_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        eng_start     = 1'b0;
        eng_reset_job = 1'b0;
        eng_abort     = 1'b0;
        load_tx       = 1'b0;
        reset_done    = 1'b0;
        byte_done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                eng_start     = !soft_rst && (reset_req || tx_full);
                eng_reset_job = !soft_rst && reset_req;
                load_tx       = !soft_rst && !reset_req && tx_full;
            end
            ST_RESET: begin
                eng_abort  = soft_rst;
                reset_done = eng_done && !soft_rst;
            end
            ST_BYTE: begin
                eng_abort = soft_rst;
                byte_done = eng_done && !soft_rst;
            end
            default: ;
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign busy_reset = (state_q == ST_RESET);
endmodule

// File: rtl/owm_irq_ctl.sv
module owm_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    input  logic drop,
    input  logic active_high,
    output logic intr
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (drop)  pend_q <= 1'b0;
        else if (raise) pend_q <= 1'b1;
        else if (ack)   pend_q <= 1'b0;
    end

    assign intr = active_high ? pend_q : ~pend_q;
endmodule

// File: rtl/owm_regif.sv
module owm_regif
    import owm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              intr,
    output logic              eng_start,
    output logic              eng_reset_job,
    output logic [REG_W-1:0]  eng_tx_byte,
    output logic              eng_abort,
    input  logic              eng_done,
    input  logic              eng_no_slave,
    input  logic [REG_W-1:0]  eng_rx_byte,
    input  logic              bus_level,
    output logic              bus_force_low,
    output logic              search_mode,
    output logic              overdrive,
    output logic [REG_W-1:0]  clk_div,
    output logic [REG_W-1:0]  ctrl
);
    logic [FLAG_W-1:0] flags_q, flags_d;
    logic [REG_W-1:0]  txbuf_q, rxbuf_q, rxbuf_d, rxsh_q, rxsh_d;
    logic [REG_W-1:0]  ien_q, div_q, ctrl_q;
    logic [4:0]        cmd_keep_q;   // command bits 7,6,4,2,1
    logic cmd_wr, data_wr, data_rd, stat_rd;
    logic soft_rst, reset_req;
    logic load_tx, reset_done, byte_done, busy, busy_reset;
    logic [FLAG_W-1:0] arm_mask, rise;

    assign cmd_wr    = reg_wr && (reg_addr == OFS_CMD);
    assign data_wr   = reg_wr && (reg_addr == OFS_DATA);
    assign data_rd   = reg_rd && (reg_addr == OFS_DATA);
    assign stat_rd   = reg_rd && (reg_addr == OFS_STAT);
    assign soft_rst  = cmd_wr && reg_wdata[5];
    assign reset_req = cmd_wr && reg_wdata[0];

    owm_job_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reset_req(reset_req),
        .tx_full(!flags_q[F_TBE]), .eng_done(eng_done),
        .eng_start(eng_start), .eng_reset_job(eng_reset_job), .eng_abort(eng_abort),
        .load_tx(load_tx), .reset_done(reset_done), .byte_done(byte_done),
        .busy(busy), .busy_reset(busy_reset)
    );

    always_comb begin
        flags_d = flags_q;
        rxbuf_d = rxbuf_q;
        rxsh_d  = rxsh_q;
        if (stat_rd) flags_d[F_PD] = 1'b0;
        if (load_tx) begin
            flags_d[F_TBE] = 1'b1;
            flags_d[F_TSE] = 1'b0;
        end
        if (data_wr) flags_d[F_TBE] = 1'b0;
        if (reset_done) begin
            flags_d[F_PD]   = 1'b1;
            flags_d[F_PRES] = eng_no_slave;
        end
        if (data_rd) begin
            if (flags_q[F_RSF]) begin
                rxbuf_d        = rxsh_q;
                flags_d[F_RSF] = 1'b0;
            end else begin
                flags_d[F_RBF] = 1'b0;
            end
        end
        if (byte_done) begin
            flags_d[F_TSE] = 1'b1;
            if (!flags_d[F_RBF]) begin
                rxbuf_d        = eng_rx_byte;
                flags_d[F_RBF] = 1'b1;
            end else begin
                rxsh_d         = eng_rx_byte;
                flags_d[F_RSF] = 1'b1;
            end
        end
        if (soft_rst) flags_d = FLAGS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q    <= FLAGS_IDLE;
            txbuf_q    <= '0;
            rxbuf_q    <= '0;
            rxsh_q     <= '0;
            ien_q      <= '0;
            div_q      <= '0;
            ctrl_q     <= '0;
            cmd_keep_q <= '0;
        end else begin
            flags_q <= flags_d;
            rxbuf_q <= rxbuf_d;
            rxsh_q  <= rxsh_d;
            if (data_wr) txbuf_q <= reg_wdata;
            if (cmd_wr)  cmd_keep_q <= {reg_wdata[7], reg_wdata[6], reg_wdata[4],
                                        reg_wdata[2], reg_wdata[1]};
            if (reg_wr && reg_addr == OFS_IEN)  ien_q  <= reg_wdata;
            if (reg_wr && reg_addr == OFS_DIV)  div_q  <= reg_wdata;
            if (reg_wr && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata;
        end
    end

    // enable bit i arms flag i, except bit 1 which is polarity
    generate
        for (genvar i = 0; i < FLAG_W; i++) begin : g_arm
            if (i == F_PRES) begin : g_pol
                assign arm_mask[i] = 1'b0;
            end else begin : g_en
                assign arm_mask[i] = ien_q[i];
            end
        end
    endgenerate

    assign rise = flags_d & ~flags_q & arm_mask;

    owm_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .raise(|rise), .ack(stat_rd),
        .drop(soft_rst), .active_high(ien_q[1]), .intr(intr)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_CMD:  reg_rdata = {cmd_keep_q[4], cmd_keep_q[3], 1'b0, cmd_keep_q[2],
                                   bus_level, cmd_keep_q[1], cmd_keep_q[0], busy_reset};
            OFS_DATA: reg_rdata = rxbuf_q;
            OFS_STAT: reg_rdata = {{(REG_W-FLAG_W){1'b0}}, flags_q};
            OFS_IEN:  reg_rdata = ien_q;
            OFS_DIV:  reg_rdata = div_q;
            OFS_CTRL: reg_rdata = ctrl_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign eng_tx_byte   = txbuf_q;
    assign bus_force_low = cmd_keep_q[1] && ien_q[6];
    assign search_mode   = cmd_keep_q[0];
    assign overdrive     = cmd_keep_q[4];
    assign clk_div       = div_q;
    assign ctrl          = ctrl_q;
endmodule

// File: rtl/owm_regif_chk.sv
module owm_regif_chk
    import owm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              eng_start,
    input logic              eng_abort,
    input logic [FLAG_W-1:0] flags_q,
    input logic              busy,
    input logic              byte_done,
    input logic              reset_done
);
    AST_DATA_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DATA) |=> !flags_q[F_TBE]); // R3

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> busy); // R5

    AST_STAT_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_STAT && !reset_done) |=> !flags_q[F_PD]); // R6

    AST_DATA_RD_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_DATA && !flags_q[F_RSF] && !byte_done)
            |=> !flags_q[F_RBF]); // R4

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> (!busy && flags_q == FLAGS_IDLE)); // R8
endmodule

bind owm_regif owm_regif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .eng_start(eng_start), .eng_abort(eng_abort), .flags_q(flags_q), .busy(busy),
    .byte_done(byte_done), .reset_done(reset_done)
);

// File: tb/tb_owm_regif.sv
`timescale 1ns/1ps
module tb_owm_regif;
    logic       clk = 0, rst_n = 0;
    logic [2:0] reg_addr = 0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       intr, eng_start, eng_reset_job, eng_abort;
    logic [7:0] eng_tx_byte;
    logic       eng_done = 0, eng_no_slave = 0, bus_level = 0;
    logic [7:0] eng_rx_byte = 0;
    logic       bus_force_low, search_mode, overdrive;
    logic [7:0] clk_div, ctrl;

    always #2.5 clk = ~clk;

    owm_regif dut (.*);

    int n_checks = 0, n_fail = 0;
    logic [7:0] model_rx = 0, cap_tx = 0;
    logic       model_ns = 0, cap_reset = 0;
    int         cnt = 0;

    // bit engine model: finishes a job 5 cycles after start
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (eng_abort) cnt <= 0;
        else if (cnt == 1) begin
            eng_done <= 1'b1; eng_rx_byte <= model_rx; eng_no_slave <= model_ns; cnt <= 0;
        end else if (cnt > 1) cnt <= cnt - 1;
        else if (eng_start) begin
            cnt <= 5; cap_tx <= eng_tx_byte; cap_reset <= eng_reset_job;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [15:0] VEC [6] = '{16'hFF3C, 16'hA5A5, 16'h00FF,
                                        16'hFF81, 16'h5A00, 16'h017E};

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(3); rst_n = 1; idle(2);
        // R1 reset state
        rd(3'd2, v); chk("R1 status", v, 8'h0C);
        rd(3'd3, v); chk("R1 enable", v, 8'h00);
        rd(3'd1, v); chk("R1 data", v, 8'h00);
        chk("R1 intr inactive", {7'd0, intr}, 8'h01);

        // R3/R4/R7 table walk, RBF interrupt active high
        wr(3'd3, 8'h12);
        chk("R7 intr idle high-pol", {7'd0, intr}, 8'h00);
        foreach (VEC[i]) begin
            model_rx = VEC[i][7:0];
            wr(3'd1, VEC[i][15:8]);
            idle(12);
            chk("R3 engine byte", cap_tx, VEC[i][15:8]);
            chk("R7 intr on rbf", {7'd0, intr}, 8'h01);
            rd(3'd2, v); chk("R3 status after byte", v, 8'h1C);
            chk("R6 intr acked", {7'd0, intr}, 8'h00);
            rd(3'd1, v); chk("R3 rx byte", v, VEC[i][7:0]);
            rd(3'd2, v); chk("R4 rbf cleared", v, 8'h0C);
        end

        // R2 register decode
        wr(3'd3, 8'h00);
        chk("R7 intr idle low-pol", {7'd0, intr}, 8'h01);
        wr(3'd4, 8'h8C); wr(3'd5, 8'h5A);
        rd(3'd4, v); chk("R2 divisor", v, 8'h8C);
        rd(3'd5, v); chk("R2 control", v, 8'h5A);
        chk("R2 clk_div port", clk_div, 8'h8C);
        chk("R2 ctrl port", ctrl, 8'h5A);

        // R5 reset job, no slave
        model_ns = 1;
        wr(3'd0, 8'h01);
        rd(3'd0, v); chk("R9 busy reset bit", v & 8'h01, 8'h01);
        idle(12);
        chk("R5 reset job kind", {7'd0, cap_reset}, 8'h01);
        rd(3'd2, v); chk("R5 no slave", v, 8'h0F);
        rd(3'd2, v); chk("R6 pd cleared", v, 8'h0E);
        model_ns = 0;
        wr(3'd0, 8'h01); idle(12);
        rd(3'd2, v); chk("R5 slave present", v, 8'h0D);
        rd(3'd2, v);

        // R5 reset request ignored while byte job runs
        model_rx = 8'h33;
        wr(3'd1, 8'hFF); wr(3'd0, 8'h01); idle(14);
        rd(3'd2, v); chk("R5 ignored when busy", v, 8'h1C);
        rd(3'd1, v);

        // R4 overrun ordering
        model_rx = 8'hA1; wr(3'd1, 8'hFF); idle(12);
        model_rx = 8'hB2; wr(3'd1, 8'hFF); idle(12);
        rd(3'd2, v); chk("R4 both full", v, 8'h3C);
        rd(3'd1, v); chk("R4 first byte", v, 8'hA1);
        rd(3'd2, v); chk("R4 shifter moved", v, 8'h1C);
        rd(3'd1, v); chk("R4 second byte", v, 8'hB2);
        rd(3'd2, v); chk("R4 drained", v, 8'h0C);

        // R7 edge arming: TBE already set raises nothing; PD raises
        wr(3'd3, 8'h06); idle(2);
        chk("R7 no edge no irq", {7'd0, intr}, 8'h00);
        wr(3'd3, 8'h03); wr(3'd0, 8'h01); idle(12);
        chk("R7 pd irq", {7'd0, intr}, 8'h01);
        rd(3'd2, v);
        chk("R6 ack pd irq", {7'd0, intr}, 8'h00);

        // R8 soft reset: clears PD, aborts byte job
        wr(3'd0, 8'h01); idle(12);
        wr(3'd0, 8'h20);
        rd(3'd2, v); chk("R8 flags after soft reset", v, 8'h0C);
        chk("R8 irq dropped", {7'd0, intr}, 8'h00);
        model_rx = 8'h77;
        wr(3'd1, 8'h55); wr(3'd0, 8'h20); idle(14);
        rd(3'd2, v); chk("R8 job abandoned", v, 8'h0C);

        // R9 direct drive and command bits
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h04);
        chk("R9 force gated", {7'd0, bus_force_low}, 8'h00);
        wr(3'd3, 8'h40);
        chk("R9 force enabled", {7'd0, bus_force_low}, 8'h01);
        bus_level = 1;
        rd(3'd0, v); chk("R9 bus level bit", v, 8'h0C);
        wr(3'd0, 8'h82);
        chk("R9 search/overdrive", {6'd0, overdrive, search_mode}, 8'h03);
        chk("R9 force released", {7'd0, bus_force_low}, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule